// File: doc/BRIEF.md
# Power-Down and Calibration Interlock Controller

This block decides when a data converter core may calibrate and when it may drop into its low-power state. It watches an asynchronous, level-sensitive power-down request and a manual calibration request. It also receives a completion pulse from the calibration engine. From these it issues a one-cycle calibration start strobe and a busy flag. It also drives a powered-down status and an output enable, which a pad ring uses to float the sample, sample-clock and over-range outputs.

The controller sets the ordering between three things: calibration after reset, calibration on request, and power-down entry and exit. A power-down request that arrives mid-calibration waits until the calibration ends. The calibration after reset is deferred while power-down is held, and it follows a selectable short or long delay. A calibration request made while powered down is discarded. It is never remembered. Once the calibration after reset has run, leaving power-down simply returns to normal operation.

Top module: `pwrcal_ctrl`

## Requirements
- R1: While `rst_n` is low, `out_en` is 0, `pwr_down` is 1, and both `cal_start` and `cal_busy` are 0.
- R2: `pd_req` reaches the state machine through a two-flop synchronizer. In normal operation, a rise of `pd_req` set up before clock edge k makes `out_en` fall and `pwr_down` rise at edge k+2.
- R3: While powered down, `out_en` stays 0. A fall of `pd_req` set up before edge k brings `out_en` back to 1 at edge k+2.
- R4: A power-down request arriving during a calibration keeps `out_en` at 1 and `cal_busy` at 1 until `cal_done` is taken. If the synchronized request is high at that edge, `out_en` falls on that same edge.
- R5: A power-down request that is withdrawn before the calibration ends leaves the block active after the calibration.
- R6: If `pd_req` is high at reset release, or goes high during the delay before the first calibration, no calibration starts while it stays high. The first calibration starts once it falls, after the synchronizer and the full delay.
- R7: After reset release with `pd_req` low, `cal_start` first pulses at edge 3+D, counting the first edge after release as edge 1. D is SHORT_DLY when `dly_long` is 0. D is LONG_DLY when `dly_long` is 1 and LONG_EN is 1.
- R8: A `cal_req` seen while powered down is ignored. No calibration starts on leaving power-down, even if `cal_req` is still held high.
- R9: A 0-to-1 change of `cal_req` while active starts exactly one calibration, with `cal_start` high on the next edge. Holding `cal_req` high starts no further calibration.
- R10: A `cal_req` edge during a calibration is ignored. No second calibration follows the first.
- R11: `cal_start` lasts one cycle. `cal_busy` rises with it and falls on the edge that takes `cal_done`. A `cal_done` pulse outside a calibration has no effect.
- R12: Leaving power-down after the first calibration has completed returns to active with no new `cal_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| pd_req | input | 1 | Power-down request level, asynchronous |
| cal_req | input | 1 | Manual calibration request, synchronous, edge-detected |
| dly_long | input | 1 | Selects the long delay before the first calibration (used only when LONG_EN=1) |
| cal_done | input | 1 | One-cycle completion pulse from the calibration engine |
| cal_start | output | 1 | One-cycle calibration start strobe |
| cal_busy | output | 1 | High while a calibration is running |
| pwr_down | output | 1 | High while in a powered-down or reset-wait state |
| out_en | output | 1 | Output driver enable; 0 floats data, data clock and over-range pins |

## Verification
The bench sweeps the calibration length against a power-down request raised at the start of a calibration. A design that let the request cut a calibration short would drop `out_en` two edges after the request rather than at the completion edge. One that missed the pending flag would stay active after a long calibration.

It measures the delay to the first calibration for both delay selections. It also repeats that measurement with power-down held across reset or raised inside the delay. An off-by-one counter shows up as a start one edge early or late, and a missing deferral shows up as a start while powered down.

Further cases target request handling: requests made while powered down and still held on exit, requests held high or re-raised mid-calibration, and stray completion pulses. Each would produce an extra start in a design that latched or level-sensed the request.

// File: rtl/pwrcal_pkg.sv
package pwrcal_pkg;

  typedef enum logic [2:0] {
    ST_RESET_WAIT = 3'd0,
    ST_POR_DELAY  = 3'd1,
    ST_CALIB      = 3'd2,
    ST_ACTIVE     = 3'd3,
    ST_PWR_DOWN   = 3'd4
  } pwrcal_state_e;

  // Delay in cycles before the first calibration for a given selection.
  function automatic int por_cycles(input logic sel, input int short_d,
                                    input int long_d, input bit long_en);
    return (long_en && sel) ? long_d : short_d;
  endfunction

endpackage

// File: rtl/pwrcal_sync.sv
module pwrcal_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pwrcal_rise.sv
module pwrcal_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/pwrcal_dly_cnt.sv
module pwrcal_dly_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwrcal_ctrl.sv
module pwrcal_ctrl
  import pwrcal_pkg::*;
#(
  parameter int SHORT_DLY = 4,
  parameter int LONG_DLY  = 12,
  parameter bit LONG_EN   = 1'b1,
  parameter int SYNC_STG  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic cal_req,
  input  logic dly_long,
  input  logic cal_done,
  output logic cal_start,
  output logic cal_busy,
  output logic pwr_down,
  output logic out_en
);
  localparam int MAX_DLY = (LONG_DLY > SHORT_DLY) ? LONG_DLY : SHORT_DLY;
  localparam int CW      = $clog2(MAX_DLY + 1);

  pwrcal_state_e state, nxt;
  logic          pd_sync;
  logic          cal_rise;
  logic          dly_zero;
  logic          dly_load_en;
  logic [CW-1:0] dly_load;
  logic          start_nxt;
  logic          start_q;

  pwrcal_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pd_req), .q_sync(pd_sync)
  );

  pwrcal_rise u_req_rise (
    .clk(clk), .rst_n(rst_n), .lvl(cal_req), .rise(cal_rise)
  );

  generate
    if (LONG_EN) begin : g_two_delays
      assign dly_load = CW'(por_cycles(dly_long, SHORT_DLY, LONG_DLY, 1'b1) - 1);
    end else begin : g_short_only
      assign dly_load = CW'(SHORT_DLY - 1);
    end
  endgenerate

  pwrcal_dly_cnt #(.W(CW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load_en), .load_val(dly_load),
    .run(state == ST_POR_DELAY), .zero(dly_zero)
  );

  always_comb begin
    nxt         = state;
    start_nxt   = 1'b0;
    dly_load_en = 1'b0;
    unique case (state)
      ST_RESET_WAIT: begin
        if (!pd_sync) begin
          nxt         = ST_POR_DELAY;
          dly_load_en = 1'b1;
        end
      end
      ST_POR_DELAY: begin
        if (pd_sync) begin
          nxt = ST_RESET_WAIT;
        end else if (dly_zero) begin
          nxt       = ST_CALIB;
          start_nxt = 1'b1;
        end
      end
      ST_CALIB: begin
        if (cal_done) nxt = pd_sync ? ST_PWR_DOWN : ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (pd_sync) begin
          nxt = ST_PWR_DOWN;
        end else if (cal_rise) begin
          nxt       = ST_CALIB;
          start_nxt = 1'b1;
        end
      end
      ST_PWR_DOWN: begin
        if (!pd_sync) nxt = ST_ACTIVE;
      end
      default: nxt = ST_RESET_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_RESET_WAIT;
      start_q <= 1'b0;
    end else begin
      state   <= nxt;
      start_q <= start_nxt;
    end
  end

  assign cal_start = start_q;
  assign cal_busy  = (state == ST_CALIB);
  assign pwr_down  = (state == ST_RESET_WAIT) || (state == ST_PWR_DOWN);
  assign out_en    = !pwr_down;
endmodule

// File: rtl/pwrcal_ctrl_chk.sv
module pwrcal_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pd_sync,
  input logic cal_done,
  input logic cal_start,
  input logic cal_busy,
  input logic pwr_down,
  input logic out_en
);
  a_r11_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  a_r11_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> cal_busy);

  a_r11_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_busy) |-> $past(cal_done));

  a_r4_busy_holds_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && !cal_done) |=> (out_en && cal_busy));

  a_r8_no_start_after_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !cal_start);

  a_r3_leave_pd_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> !$past(pd_sync));

  a_r2_enter_pd_on_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(pd_sync));
endmodule

bind pwrcal_ctrl pwrcal_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pd_sync(pd_sync), .cal_done(cal_done),
  .cal_start(cal_start), .cal_busy(cal_busy), .pwr_down(pwr_down),
  .out_en(out_en)
);

// File: tb/pwrcal_ctrl_bench.sv
module pwrcal_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_D    = 4;
  localparam int LONG_D     = 12;

  logic clk = 1'b0;
  logic rst_n, pd_req, cal_req, dly_long, cal_done;
  logic cal_start, cal_busy, pwr_down, out_en;

  int checks = 0;
  int errors = 0;
  int n_starts = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrcal_ctrl #(.SHORT_DLY(SHORT_D), .LONG_DLY(LONG_D), .LONG_EN(1'b1)) u_pwrcal_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .cal_req(cal_req),
    .dly_long(dly_long), .cal_done(cal_done), .cal_start(cal_start),
    .cal_busy(cal_busy), .pwr_down(pwr_down), .out_en(out_en)
  );

  always @(negedge clk) if (rst_n && cal_start === 1'b1) n_starts++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic do_reset(input logic pd, input logic sel);
    rst_n = 1'b0; pd_req = pd; dly_long = sel; cal_req = 1'b0; cal_done = 1'b0;
    repeat (3) tick();
    chk(out_en == 1'b0 && pwr_down == 1'b1, "R1 outputs floated in reset", out_en, 0);
    chk(cal_start == 1'b0 && cal_busy == 1'b0, "R1 no calibration in reset", cal_busy, 0);
    rst_n = 1'b1;
  endtask

  task automatic edges_to_start(output int e);
    e = 0;
    do begin tick(); e++; end while (cal_start !== 1'b1 && e < 200);
  endtask

  task automatic finish_cal();
    cal_done = 1'b1; tick(); cal_done = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int e, base;
    // R7: delay before the first calibration, both selections
    for (int sel = 0; sel < 2; sel++) begin
      do_reset(1'b0, sel[0]);
      edges_to_start(e);
      chk(e == 3 + (sel ? LONG_D : SHORT_D), "R7 first start edge", e, 3 + (sel ? LONG_D : SHORT_D));
      chk(cal_busy == 1'b1 && out_en == 1'b1, "R11 busy with start", cal_busy, 1);
      tick();
      chk(cal_start == 1'b0 && cal_busy == 1'b1, "R11 strobe one cycle", cal_start, 0);
      finish_cal();
      chk(cal_busy == 1'b0 && out_en == 1'b1, "R11 busy ends on done", cal_busy, 0);
    end

    // R9 / R10: single start per edge, held level and mid-calibration edges ignored
    base = n_starts;
    cal_req = 1'b1; tick();
    chk(cal_start == 1'b1 && cal_busy == 1'b1, "R9 start on request edge", cal_start, 1);
    repeat (4) tick();
    cal_req = 1'b0; tick(); cal_req = 1'b1; tick();
    finish_cal();
    repeat (6) tick();
    chk(n_starts - base == 1, "R9 R10 exactly one calibration", n_starts - base, 1);
    cal_req = 1'b0; tick();

    // R11: stray completion pulse has no effect
    base = n_starts;
    finish_cal(); repeat (3) tick();
    chk(cal_busy == 1'b0 && out_en == 1'b1 && n_starts == base, "R11 stray done ignored", cal_busy, 0);

    // R2 / R3: synchronizer latency into power-down
    pd_req = 1'b1;
    tick(); chk(out_en == 1'b1, "R2 still active edge 1", out_en, 1);
    tick(); chk(out_en == 1'b1, "R2 still active edge 2", out_en, 1);
    tick(); chk(out_en == 1'b0 && pwr_down == 1'b1, "R2 floated at edge 3", out_en, 0);

    // R8: requests while powered down are dropped, even held across exit
    base = n_starts;
    cal_req = 1'b1; tick(); cal_req = 1'b0; tick(); cal_req = 1'b1; repeat (3) tick();
    chk(out_en == 1'b0 && n_starts == base, "R3 R8 stays down, no start", n_starts - base, 0);
    pd_req = 1'b0;
    tick(); chk(out_en == 1'b0, "R3 exit not before edge 3 (1)", out_en, 0);
    tick(); chk(out_en == 1'b0, "R3 exit not before edge 3 (2)", out_en, 0);
    tick(); chk(out_en == 1'b1 && pwr_down == 1'b0, "R3 active at edge 3", out_en, 1);
    repeat (10) tick();
    chk(n_starts == base, "R8 R12 no start after exit", n_starts - base, 0);
    cal_req = 1'b0; tick();

    // R4 / R12: power-down raised at calibration start, swept over calibration length
    for (int c = 0; c < 6; c++) begin
      int drop;
      drop = (c + 1 > 3) ? c + 1 : 3;
      cal_req = 1'b1; tick(); cal_req = 1'b0;
      chk(cal_start == 1'b1, "R9 sweep start", cal_start, 1);
      pd_req = 1'b1; cal_done = (c == 0);
      for (int ed = 1; ed <= 8; ed++) begin
        tick();
        chk(cal_busy == (ed <= c), "R4 busy until done", cal_busy, int'(ed <= c));
        chk(out_en == (ed < drop), "R4 deferred power-down", out_en, int'(ed < drop));
        cal_done = (ed == c);
      end
      base = n_starts;
      pd_req = 1'b0; repeat (4) tick();
      chk(out_en == 1'b1 && cal_busy == 1'b0 && n_starts == base, "R12 resume without calibration", n_starts - base, 0);
    end

    // R5: request withdrawn before the calibration ends
    cal_req = 1'b1; tick(); cal_req = 1'b0;
    pd_req = 1'b1; tick(); pd_req = 1'b0; repeat (4) tick();
    chk(out_en == 1'b1 && cal_busy == 1'b1, "R5 calibrating, still active", out_en, 1);
    finish_cal(); repeat (4) tick();
    chk(out_en == 1'b1 && pwr_down == 1'b0, "R5 active after calibration", out_en, 1);

    // R6: power-down held across reset defers the first calibration
    do_reset(1'b1, 1'b0);
    base = n_starts;
    cal_req = 1'b1; repeat (30) tick(); cal_req = 1'b0;
    chk(n_starts == base && out_en == 1'b0, "R6 no calibration while held", n_starts - base, 0);
    pd_req = 1'b0;
    edges_to_start(e);
    chk(e == 3 + SHORT_D, "R6 deferred start edge", e, 3 + SHORT_D);
    finish_cal();

    // R6: power-down raised inside the long delay
    do_reset(1'b0, 1'b1);
    repeat (4) tick();
    pd_req = 1'b1;
    base = n_starts;
    repeat (30) tick();
    chk(n_starts == base && out_en == 1'b0, "R6 no start after delay interrupted", n_starts - base, 0);
    pd_req = 1'b0;
    edges_to_start(e);
    chk(e == 3 + LONG_D, "R6 R7 full long delay after release", e, 3 + LONG_D);
    finish_cal();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule